// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Frame Engine

This block holds the bit-level transmitter and receiver of an asynchronous serial port. It is advanced by a single-cycle enable that pulses eight times per bit period, so every bit on the line lasts eight enable pulses. Baud generation, FIFOs and software-visible registers live elsewhere. The engine only turns bytes into line frames and line frames back into bytes.

A frame is a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional parity bit, then a high stop level. Parity has four variants, chosen by a 2-bit code. The transmitter can append a second stop bit. The receiver always checks a single stop bit and returns at once to searching for the next start edge. Each received character is reported with parity, framing and line-break flags. A loopback switch connects the transmit path straight to the receive path. A break control forces the outgoing line low.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A transmitted frame starts with one low start bit, followed by the data bits LSB first: 8 bits when `cfg_data8`=1, 7 bits when `cfg_data8`=0. Every bit lasts exactly 8 `tick` pulses.
- R3: When `cfg_par_en`=1, one parity bit follows the data. `cfg_par_mode` codes are 0 = odd (the data ones plus the parity bit make an odd count), 1 = even, 2 = constant 0, 3 = constant 1.
- R4: The transmitter ends a frame with one high stop bit, or two when `cfg_two_stop`=1. `tx_ready` is low during the 8·N-th tick of an N-bit frame and high in the cycle after it.
- R5: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` drops on the next cycle. Frame settings are captured at that edge.
- R6: A low level seen at a tick while idle begins a start bit only if the line is still low 4 ticks later (the bit centre). Otherwise the receiver goes back to searching and reports nothing.
- R7: Each later bit is sampled at its centre. After the stop sample, `rx_valid` pulses for one cycle with `rx_data`. In 7-bit mode `rx_data[7]` is 0.
- R8: With parity enabled, `rx_par_err` is 1 when the received parity bit differs from the value given by the R3 codes.
- R9: `rx_frm_err` is 1 when the stop sample is low. The receiver checks one stop bit whatever `cfg_two_stop` says, so frames with a single stop bit sent back to back are all received.
- R10: `rx_break` is 1 when every sample of the frame is low, including parity and stop. In that case `rx_frm_err` is also 1 and `rx_data` is 0.
- R11: With `cfg_loopback`=1 the transmitted frame reaches the receiver internally. `txd` stays high and `rxd` is ignored.
- R12: While `cfg_break`=1 (and loopback is off), `txd` is low from the second clock on. `txd` returns to the line level once `cfg_break` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable at eight times the baud rate |
| cfg_data8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_two_stop | input | 1 | Transmit two stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity code: 0 odd, 1 even, 2 zero, 3 one |
| cfg_loopback | input | 1 | Route transmit path into the receiver |
| cfg_break | input | 1 | Force the transmit line low |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe per received character |
| rx_par_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frm_err | output | 1 | Stop sample low, valid with rx_valid |
| rx_break | output | 1 | Whole frame low, valid with rx_valid |

## Verification
A stuck or skipped bit-phase counter in the transmitter shows at the first sampled bit centre on `txd`, or as `tx_ready` returning one tick early or late, so it appears within one frame. A receiver that has the wrong bit index or keeps stale frame settings shows as a wrong byte or a spurious flag on the very next `rx_valid`. A bad start qualification produces an extra character that the scoreboard did not expect. In loopback, a receiver that does not return to its search state fails the following character, so errors never stay hidden for more than one frame.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_SPACE = 2'd2,
    PAR_MARK  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } ser_state_e;

  typedef struct packed {
    logic      w8;
    logic      two_stop;
    logic      par_en;
    par_mode_e mode;
  } frame_cfg_t;

  // Parity bit for a data word under a given width and mode
  function automatic logic parity_bit(input logic [7:0] d, input logic w8,
                                      input par_mode_e m);
    logic ones;
    ones = w8 ? ^d : ^d[6:0];
    unique case (m)
      PAR_ODD:   parity_bit = ~ones;
      PAR_EVEN:  parity_bit = ones;
      PAR_SPACE: parity_bit = 1'b0;
      default:   parity_bit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int OVERSAMPLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       ser
);

  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  ser_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      sh_q, sh_d;
  frame_cfg_t      cfg_q, cfg_d;
  logic            par_q, par_d;
  logic            stop2_q, stop2_d;
  logic [2:0]      last_idx;

  assign last_idx = cfg_q.w8 ? 3'd7 : 3'd6;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    cfg_d   = cfg_q;
    par_d   = par_q;
    stop2_d = stop2_q;
    if (st_q == ST_IDLE) begin
      if (in_valid) begin
        sh_d    = in_data;
        cfg_d   = cfg;
        par_d   = parity_bit(in_data, cfg.w8, cfg.mode);
        ph_d    = '0;
        idx_d   = '0;
        stop2_d = 1'b0;
        st_d    = ST_START;
      end
    end else if (tick) begin
      if (ph_q != PH_LAST) begin
        ph_d = ph_q + 1'b1;
      end else begin
        ph_d = '0;
        unique case (st_q)
          ST_START: begin
            st_d  = ST_DATA;
            idx_d = '0;
          end
          ST_DATA: begin
            if (idx_q == last_idx) st_d = cfg_q.par_en ? ST_PAR : ST_STOP;
            else                   idx_d = idx_q + 3'd1;
          end
          ST_PAR: st_d = ST_STOP;
          ST_STOP: begin
            if (cfg_q.two_stop && !stop2_q) stop2_d = 1'b1;
            else                            st_d    = ST_IDLE;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      cfg_q   <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      cfg_q   <= cfg_d;
      par_q   <= par_d;
      stop2_q <= stop2_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: ser = 1'b0;
      ST_DATA:  ser = sh_q[idx_q];
      ST_PAR:   ser = par_q;
      default:  ser = 1'b1;
    endcase
  end

  assign in_ready = (st_q == ST_IDLE);

  // R5, R2: an accepted byte makes the block busy and puts out the start bit
  p_accept_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !ser));

  // R2: the bit phase only moves on a tick
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !tick) |=> $stable(ph_q));

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OVERSAMPLE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_w8,
  input  logic       cfg_par_en,
  input  par_mode_e  cfg_mode,
  input  logic       line,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_par_err,
  output logic       out_frm_err,
  output logic       out_break
);

  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);

  ser_state_e      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      buf_q, buf_d;
  logic            w8_q, w8_d, pen_q, pen_d;
  par_mode_e       mode_q, mode_d;
  logic            psmp_q, psmp_d;
  logic            hi_q, hi_d;
  logic [7:0]      od_q, od_d;
  logic            ov_q, ov_d, ope_q, ope_d, ofe_q, ofe_d, obk_q, obk_d;
  logic [2:0]      last_idx;

  assign last_idx = w8_q ? 3'd7 : 3'd6;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    buf_d  = buf_q;
    w8_d   = w8_q;
    pen_d  = pen_q;
    mode_d = mode_q;
    psmp_d = psmp_q;
    hi_d   = hi_q;
    od_d   = od_q;
    ov_d   = 1'b0;
    ope_d  = ope_q;
    ofe_d  = ofe_q;
    obk_d  = obk_q;
    if (st_q == ST_IDLE) begin
      if (tick && !line) begin
        st_d = ST_START;
        ph_d = '0;
      end
    end else if (st_q == ST_START) begin
      if (tick) begin
        if (ph_q != PH_MID) begin
          ph_d = ph_q + 1'b1;
        end else if (line) begin
          st_d = ST_IDLE;
        end else begin
          st_d   = ST_DATA;
          ph_d   = '0;
          idx_d  = '0;
          buf_d  = '0;
          hi_d   = 1'b0;
          w8_d   = cfg_w8;
          pen_d  = cfg_par_en;
          mode_d = cfg_mode;
        end
      end
    end else if (tick) begin
      if (ph_q != PH_LAST) begin
        ph_d = ph_q + 1'b1;
      end else begin
        ph_d = '0;
        unique case (st_q)
          ST_DATA: begin
            buf_d[idx_q] = line;
            hi_d         = hi_q | line;
            if (idx_q == last_idx) st_d = pen_q ? ST_PAR : ST_STOP;
            else                   idx_d = idx_q + 3'd1;
          end
          ST_PAR: begin
            psmp_d = line;
            hi_d   = hi_q | line;
            st_d   = ST_STOP;
          end
          default: begin
            od_d  = buf_q;
            ov_d  = 1'b1;
            ope_d = pen_q && (psmp_q != parity_bit(buf_q, w8_q, mode_q));
            ofe_d = !line;
            obk_d = !line && !hi_q;
            st_d  = ST_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      buf_q  <= '0;
      w8_q   <= 1'b1;
      pen_q  <= 1'b0;
      mode_q <= PAR_ODD;
      psmp_q <= 1'b0;
      hi_q   <= 1'b0;
      od_q   <= '0;
      ov_q   <= 1'b0;
      ope_q  <= 1'b0;
      ofe_q  <= 1'b0;
      obk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      buf_q  <= buf_d;
      w8_q   <= w8_d;
      pen_q  <= pen_d;
      mode_q <= mode_d;
      psmp_q <= psmp_d;
      hi_q   <= hi_d;
      od_q   <= od_d;
      ov_q   <= ov_d;
      ope_q  <= ope_d;
      ofe_q  <= ofe_d;
      obk_q  <= obk_d;
    end
  end

  assign out_data    = od_q;
  assign out_valid   = ov_q;
  assign out_par_err = ope_q;
  assign out_frm_err = ofe_q;
  assign out_break   = obk_q;

  // R7: one strobe per character
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: seven-bit characters carry a zero top bit
  p_seven_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !w8_q) |-> !out_data[7]);

  // R10: a break is also a framing error on an all-zero byte
  p_break_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_break) |-> (out_frm_err && out_data == 8'h00));

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int OVERSAMPLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_data8,
  input  logic       cfg_two_stop,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_mode,
  input  logic       cfg_loopback,
  input  logic       cfg_break,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  output logic       rx_break
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  // input synchroniser for the external line
  logic [SYNC_STAGES-1:0] rx_sync_q;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) rx_sync_q <= '1;
        else          rx_sync_q <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) rx_sync_q <= '1;
        else          rx_sync_q <= {rx_sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  frame_cfg_t cfg;
  assign cfg = '{w8: cfg_data8, two_stop: cfg_two_stop, par_en: cfg_par_en,
                 mode: par_mode_e'(cfg_par_mode)};

  logic tx_ser, line_int, rx_line, txd_q;

  uart_fe_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick     (tick),
    .cfg      (cfg),
    .in_data  (tx_data),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .ser      (tx_ser)
  );

  assign line_int = cfg_break ? 1'b0 : tx_ser;
  assign rx_line  = cfg_loopback ? line_int : rx_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) txd_q <= 1'b1;
    else          txd_q <= cfg_loopback ? 1'b1 : line_int;
  end
  assign txd = txd_q;

  uart_fe_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .tick        (tick),
    .cfg_w8      (cfg_data8),
    .cfg_par_en  (cfg_par_en),
    .cfg_mode    (par_mode_e'(cfg_par_mode)),
    .line        (rx_line),
    .out_data    (rx_data),
    .out_valid   (rx_valid),
    .out_par_err (rx_par_err),
    .out_frm_err (rx_frm_err),
    .out_break   (rx_break)
  );

  // R11: the pin stays idle while loopback has been on for a cycle
  p_loop_idle_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_loopback && $past(cfg_loopback)) |-> txd);

  // R1: nothing is received while the reset is being released
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s_n |-> !rx_valid);

endmodule

// File: tb/sim_uart_frame_engine.sv
module sim_uart_frame_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       cfg_data8, cfg_two_stop, cfg_par_en, cfg_loopback, cfg_break;
  logic [1:0] cfg_par_mode;
  logic [7:0] tx_data;
  logic       tx_valid, tx_ready, txd, rxd;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_break;

  int n_checks = 0;
  int n_fail   = 0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  logic [1:0] tdiv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick = (tdiv == 2'd3);

  uart_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_data8(cfg_data8), .cfg_two_stop(cfg_two_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
    .cfg_loopback(cfg_loopback), .cfg_break(cfg_break),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected character", {rx_break, rx_frm_err, rx_par_err, rx_data}, 0);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rx_break, rx_frm_err, rx_par_err, rx_data} == e, t, "received item",
              {rx_break, rx_frm_err, rx_par_err, rx_data}, e);
      end
    end
  end

  task automatic next_tick();
    do @(negedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) next_tick();
  endtask

  function automatic logic bench_par(input logic [7:0] d, input logic w8,
                                     input logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (i < 7 || w8) ones += int'(d[i]);
    case (m)
      2'd0: return (ones % 2 == 0);
      2'd1: return (ones % 2 == 1);
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic set_cfg(input logic w8, input logic two, input logic pen,
                         input logic [1:0] m);
    @(negedge clk);
    cfg_data8 = w8; cfg_two_stop = two; cfg_par_en = pen; cfg_par_mode = m;
  endtask

  task automatic accept(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // send one byte and sample txd at every bit centre
  task automatic tx_check(input logic [7:0] d, input string req);
    logic exp_bits[16];
    int n = 0;
    exp_bits[n++] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < 7 || cfg_data8) exp_bits[n++] = d[i];
    if (cfg_par_en) exp_bits[n++] = bench_par(d, cfg_data8, cfg_par_mode);
    exp_bits[n++] = 1'b1;
    if (cfg_two_stop) exp_bits[n++] = 1'b1;
    accept(d);
    for (int k = 0; k < n; k++) begin
      ticks(k == 0 ? 4 : 8);
      check(txd == exp_bits[k], req, $sformatf("tx bit %0d", k), txd, exp_bits[k]);
    end
    ticks(3);
    check(tx_ready == 1'b0, "R4", "ready in last tick", tx_ready, 0);
    ticks(1);
    check(tx_ready == 1'b1, "R4", "ready after frame", tx_ready, 1);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    ticks(8);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic bad_par,
                         input logic stop_lvl, input int gap, input string req);
    logic [7:0] ed;
    logic p, pe;
    ed = cfg_data8 ? d : {1'b0, d[6:0]};
    p  = bench_par(d, cfg_data8, cfg_par_mode) ^ bad_par;
    pe = cfg_par_en && bad_par;
    exp_q.push_back({!stop_lvl && ed == 8'h00 && (!cfg_par_en || !p), !stop_lvl, pe, ed});
    tag_q.push_back(req);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) if (i < 7 || cfg_data8) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(p);
    drive_bit(stop_lvl);
    rxd = 1'b1;
    ticks(gap);
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (exp_q.size() > 0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    check(exp_q.size() == 0, req, "pending characters", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; tx_valid = 1'b0; tx_data = '0;
    cfg_data8 = 1'b1; cfg_two_stop = 1'b0; cfg_par_en = 1'b0; cfg_par_mode = 2'd0;
    cfg_loopback = 1'b0; cfg_break = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1", "txd idle", txd, 1);
    check(tx_ready == 1'b1, "R1", "tx_ready idle", tx_ready, 1);
    check(rx_valid == 1'b0, "R1", "rx_valid idle", rx_valid, 0);

    // transmit: widths, parity codes, stop counts
    set_cfg(1, 0, 0, 2'd0); tx_check(8'hA5, "R2");
    set_cfg(0, 0, 0, 2'd0); tx_check(8'hC3, "R2");
    set_cfg(1, 0, 1, 2'd0); tx_check(8'h31, "R3");
    set_cfg(1, 0, 1, 2'd1); tx_check(8'h31, "R3");
    set_cfg(0, 0, 1, 2'd2); tx_check(8'h7F, "R3");
    set_cfg(1, 1, 1, 2'd3); tx_check(8'h00, "R4");

    // R5: settings captured at acceptance
    set_cfg(1, 0, 0, 2'd0);
    accept(8'hFF);
    cfg_data8 = 1'b0; cfg_par_en = 1'b1;
    ticks(8 * 8 + 4);
    check(txd == 1'b1, "R5", "8th data bit after cfg change", txd, 1);
    ticks(8);
    check(txd == 1'b1, "R5", "stop where parity would be", txd, 1);
    ticks(4);
    check(tx_ready == 1'b1, "R5", "frame length kept", tx_ready, 1);

    // receive: plain, 7-bit, parity good and bad
    set_cfg(1, 0, 0, 2'd0); rx_send(8'h5A, 0, 1, 8, "R7");
    set_cfg(0, 0, 0, 2'd0); rx_send(8'hB6, 0, 1, 8, "R7");
    set_cfg(1, 0, 1, 2'd0); rx_send(8'h13, 0, 1, 8, "R8");
    set_cfg(1, 0, 1, 2'd1); rx_send(8'h13, 1, 1, 8, "R8");
    set_cfg(0, 0, 1, 2'd3); rx_send(8'h44, 1, 1, 8, "R8");
    set_cfg(1, 0, 1, 2'd2); rx_send(8'h44, 0, 1, 8, "R8");
    drain("R8");

    // R9: framing error, and back-to-back single-stop frames with two_stop set
    set_cfg(1, 0, 0, 2'd0); rx_send(8'h81, 0, 0, 8, "R9");
    set_cfg(1, 1, 0, 2'd0);
    rx_send(8'h11, 0, 1, 0, "R9");
    rx_send(8'h22, 0, 1, 0, "R9");
    rx_send(8'h33, 0, 1, 8, "R9");
    drain("R9");

    // R6: a short low pulse is rejected
    rxd = 1'b0; ticks(2); rxd = 1'b1; ticks(20);
    check(exp_q.size() == 0, "R6", "glitch queue", exp_q.size(), 0);

    // R10: break on the line for one frame minus two ticks
    set_cfg(1, 0, 0, 2'd0);
    exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00}); tag_q.push_back("R10");
    rxd = 1'b0; ticks(10 * 8 - 2); rxd = 1'b1; ticks(24);
    drain("R10");

    // R11: loopback ignores rxd and keeps txd high
    cfg_loopback = 1'b1;
    rxd = 1'b0;
    set_cfg(1, 0, 1, 2'd1);
    exp_q.push_back({3'b000, 8'h96}); tag_q.push_back("R11");
    accept(8'h96);
    ticks(20);
    check(txd == 1'b1, "R11", "txd during loopback", txd, 1);
    drain("R11");
    set_cfg(0, 0, 0, 2'd0);
    exp_q.push_back({3'b000, 8'h2C}); tag_q.push_back("R11");
    accept(8'hAC);
    drain("R11");
    rxd = 1'b1;
    cfg_loopback = 1'b0;
    ticks(4);

    // R12: break command
    @(negedge clk); cfg_break = 1'b1;
    @(negedge clk); @(negedge clk);
    check(txd == 1'b0, "R12", "txd under break", txd, 0);
    ticks(30);
    check(txd == 1'b0, "R12", "txd held low", txd, 0);
    cfg_break = 1'b0;
    @(negedge clk); @(negedge clk);
    check(txd == 1'b1, "R12", "txd released", txd, 1);

    ticks(16);
    check(exp_q.size() == 0, "R7", "scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule